// File: doc/BRIEF.md
# Receive Byte Queue with Level and Stale-Data Interrupt

This block holds received bytes between a serial receiver and the host. Each strobe from the deserializer pushes one byte, and each host strobe pops one byte. The block raises an interrupt request in two cases. The first is when the number of stored bytes reaches a level chosen by a 2-bit code. The second is when stored data has gone unread for a fixed number of receiver bit times.

The storage depth is chosen at run time: either a small queue (8 bytes by default) or a large one (256 bytes by default). Each threshold code maps to a different fill level in each depth. The two bits of the code arrive as separate inputs, because they come from two different mode registers. A change to the size, code or watchdog enable takes effect immediately. A change of size empties the queue.

Top module: `rx_fifo_irq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `count` is 0 and `rx_ready`, `full`, `overrun`, `irq` and `rd_data` are all 0.
- R2: Bytes are popped in the order they were pushed. The popped byte appears on `rd_data` after the clock edge that samples `rd_en`. `rx_ready` is high exactly when `count` is non-zero.
- R3: In small mode (`size_large`=0), the code {`thr_hi`,`thr_lo`} selects the level at which `irq` is raised. The levels are: 00 at 1 or more bytes, 01 at 3 or more, 10 at 6 or more, and 11 at 8 bytes.
- R4: In large mode (`size_large`=1), the same codes select 1 or more, 128 or more, 192 or more, and 256 bytes.
- R5: When `count` equals the depth, `full` is high. A push in that state is dropped and `count` is unchanged. The push also sets `overrun`, which stays set until reset.
- R6: A pop while `count` is 0 leaves `rd_data` and `count` unchanged.
- R7: Suppose `wdog_en` is high and the queue holds data. If 64 `bit_tick` pulses pass with no accepted push or pop, `irq` is high by the second clock edge after the 64th pulse.
- R8: The stale-data count restarts on every accepted push or pop. It does not advance, and cannot fire, while the queue is empty. `irq` is never high while `count` is 0.
- R9: Once the stale-data event has fired, it stays asserted through later pushes. It is cleared by a pop, by the queue becoming empty, or by `wdog_en` going low.
- R10: The threshold code and `wdog_en` affect `irq` in the same cycle they change, with no clock edge needed.
- R11: On a clock edge where `size_large` differs from its value at the previous edge, the queue is emptied. Any push or pop in that cycle is ignored.
- R12: A push and a pop in the same cycle are both performed, provided the queue is neither empty nor full. `count` is then unchanged. When the queue is full, the pop is performed and the push is dropped as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push strobe from the deserializer |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Host pop strobe |
| bit_tick | input | 1 | One pulse per receiver 1x bit time |
| size_large | input | 1 | 0 selects the small depth, 1 the large depth |
| thr_hi | input | 1 | Upper bit of the threshold code |
| thr_lo | input | 1 | Lower bit of the threshold code |
| wdog_en | input | 1 | Enables the stale-data interrupt |
| rd_data | output | 8 | Last popped byte |
| rx_ready | output | 1 | Queue holds at least one byte |
| full | output | 1 | Queue holds as many bytes as the selected depth |
| count | output | 9 | Number of stored bytes |
| overrun | output | 1 | Sticky flag: a push was dropped |
| irq | output | 1 | Receive interrupt request |

## Verification
Some properties hold on every cycle, and the checker enforces those:
- the count bound;
- dropped pushes on a full queue, and the sticky overrun flag;
- pops on an empty queue having no effect;
- `irq` staying low while the queue is empty, and staying high under code 00 whenever data is held;
- the flush on a size change.

Other behaviour can only be shown by the bench's scenarios:
- the exact level for every code in both depths, which a vector table walks at each boundary;
- byte ordering;
- the 63-versus-64 tick edge of the stale-data interrupt, its restart on a push, and its latching across pushes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    THR_ANY  = 2'b00,
    THR_LOW  = 2'b01,
    THR_MID  = 2'b10,
    THR_ALL  = 2'b11
  } thr_code_e;
endpackage

// File: rtl/rxq_store.sv
// Dual-pointer byte storage with registered read port (block RAM style).
module rxq_store #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] mask,
  output logic [DW-1:0] rdata
);
  localparam int SLOTS = 2 ** AW;

  logic [DW-1:0] mem [SLOTS];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (we) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      rdata <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (we) wp <= (wp + AW'(1)) & mask;
      if (re) begin
        rdata <= mem[rp];
        rp    <= (rp + AW'(1)) & mask;
      end
    end
  end
endmodule

// File: rtl/rxq_level.sv
// Maps the threshold code to a fill level for the selected depth.
module rxq_level
  import rxq_pkg::*;
#(
  parameter int CW       = 9,
  parameter int SM_DEPTH = 8,
  parameter int LG_DEPTH = 256,
  parameter int SM_LOW   = 3,
  parameter int SM_MID   = 6
) (
  input  logic [CW-1:0] count,
  input  logic          size_large,
  input  thr_code_e     code,
  output logic          hit
);
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam logic [CW-1:0] S_LOW  = CW'(SM_LOW);
  localparam logic [CW-1:0] S_MID  = CW'(SM_MID);
  localparam logic [CW-1:0] S_ALL  = CW'(SM_DEPTH);
  localparam logic [CW-1:0] L_LOW  = CW'(LG_DEPTH / 2);
  localparam logic [CW-1:0] L_MID  = CW'((LG_DEPTH * 3) / 4);
  localparam logic [CW-1:0] L_ALL  = CW'(LG_DEPTH);

  logic [CW-1:0] lvl;

  always_comb begin
    unique case (code)
      THR_ANY: lvl = ONE;
      THR_LOW: lvl = size_large ? L_LOW : S_LOW;
      THR_MID: lvl = size_large ? L_MID : S_MID;
      default: lvl = size_large ? L_ALL : S_ALL;
    endcase
    hit = (count >= lvl);
  end
endmodule

// File: rtl/rxq_watchdog.sv
// Counts bit times while data is held; latches a stale-data event.
module rxq_watchdog #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic enable,
  input  logic holding,
  input  logic restart,
  input  logic host_rd,
  input  logic drain,
  output logic fired
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TOP = TW'(LIMIT);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !holding) tcnt <= '0;
    else if (tick && tcnt != TOP) tcnt <= tcnt + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable || drain || host_rd) fired <= 1'b0;
    else if (tcnt == TOP) fired <= 1'b1;
  end
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
  import rxq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SM_DEPTH = 8,
  parameter int LG_DEPTH = 256,
  parameter int SM_LOW   = 3,
  parameter int SM_MID   = 6,
  parameter int WD_TICKS = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [DW-1:0]                  wr_data,
  input  logic                           rd_en,
  input  logic                           bit_tick,
  input  logic                           size_large,
  input  logic                           thr_hi,
  input  logic                           thr_lo,
  input  logic                           wdog_en,
  output logic [DW-1:0]                  rd_data,
  output logic                           rx_ready,
  output logic                           full,
  output logic [$clog2(LG_DEPTH):0]      count,
  output logic                           overrun,
  output logic                           irq
);
  localparam int AW = $clog2(LG_DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] SM_MASK = AW'(SM_DEPTH - 1);
  localparam logic [AW-1:0] LG_MASK = AW'(LG_DEPTH - 1);

  logic          size_q;
  logic [CW-1:0] count_q, count_d, cap;
  logic          flush, acc_wr, acc_rd, room;
  logic          lvl_hit, wd_fired;
  thr_code_e     code;

  assign cap    = size_large ? CW'(LG_DEPTH) : CW'(SM_DEPTH);
  assign flush  = (size_large != size_q);
  assign room   = (count_q < cap);
  assign acc_wr = wr_en && !flush && room;
  assign acc_rd = rd_en && !flush && (count_q != '0);
  assign count_d = flush ? '0 : (count_q + CW'(acc_wr) - CW'(acc_rd));
  assign code   = thr_code_e'({thr_hi, thr_lo});

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q   <= size_large;
      count_q  <= '0;
      rx_ready <= 1'b0;
      full     <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      size_q   <= size_large;
      count_q  <= count_d;
      rx_ready <= (count_d != '0);
      full     <= (count_d == cap);
      if (wr_en && !flush && !room) overrun <= 1'b1;
    end
  end

  rxq_store #(.DW(DW), .AW(AW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .we    (acc_wr),
    .wdata (wr_data),
    .re    (acc_rd),
    .mask  (size_q ? LG_MASK : SM_MASK),
    .rdata (rd_data)
  );

  rxq_level #(
    .CW(CW), .SM_DEPTH(SM_DEPTH), .LG_DEPTH(LG_DEPTH),
    .SM_LOW(SM_LOW), .SM_MID(SM_MID)
  ) u_level (
    .count      (count_q),
    .size_large (size_large),
    .code       (code),
    .hit        (lvl_hit)
  );

  rxq_watchdog #(.LIMIT(WD_TICKS)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .tick    (bit_tick),
    .enable  (wdog_en),
    .holding (count_q != '0),
    .restart (acc_wr || acc_rd || flush),
    .host_rd (acc_rd),
    .drain   (count_d == '0),
    .fired   (wd_fired)
  );

  assign count = count_q;
  assign irq   = lvl_hit || (wd_fired && wdog_en);
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DW       = 8,
  parameter int SM_DEPTH = 8,
  parameter int LG_DEPTH = 256,
  parameter int CW       = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          size_large,
  input logic          thr_hi,
  input logic          thr_lo,
  input logic          wdog_en,
  input logic [DW-1:0] rd_data,
  input logic          rx_ready,
  input logic          full,
  input logic [CW-1:0] count,
  input logic          overrun,
  input logic          irq
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !overrun && !irq && !full));

  assert_ready_match_R2: assert property (@(posedge clk) disable iff (rst)
    rx_ready == (count != '0));

  assert_code0_irq_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !thr_hi && !thr_lo) |-> irq);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    $stable(size_large) |-> (count <= (size_large ? CW'(LG_DEPTH) : CW'(SM_DEPTH))));

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && $stable(size_large)) |=> (overrun && count == $past(count)));

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && rd_en && !wr_en) |=> ($stable(rd_data) && count == '0));

  assert_no_irq_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !irq);

  assert_wd_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!wdog_en && !size_large && thr_hi && thr_lo && !full && $stable(size_large)) |-> !irq);

  assert_size_flush_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(size_large) |=> (count == '0));
endmodule

bind rx_fifo_irq rxq_checker #(
  .DW(DW), .SM_DEPTH(SM_DEPTH), .LG_DEPTH(LG_DEPTH), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .size_large (size_large),
  .thr_hi     (thr_hi),
  .thr_lo     (thr_lo),
  .wdog_en    (wdog_en),
  .rd_data    (rd_data),
  .rx_ready   (rx_ready),
  .full       (full),
  .count      (count),
  .overrun    (overrun),
  .irq        (irq)
);

// File: tb/rx_fifo_irq_tb.sv
module rx_fifo_irq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, bit_tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       size_large = 1'b0, thr_hi = 1'b0, thr_lo = 1'b0, wdog_en = 1'b0;
  logic [7:0] rd_data;
  logic       rx_ready, full, overrun, irq;
  logic [8:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_fifo_irq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .bit_tick(bit_tick), .size_large(size_large), .thr_hi(thr_hi),
    .thr_lo(thr_lo), .wdog_en(wdog_en), .rd_data(rd_data),
    .rx_ready(rx_ready), .full(full), .count(count), .overrun(overrun),
    .irq(irq)
  );

  // {size_large, thr_hi, thr_lo, bytes[8:0], expected irq}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {3'b000, 9'd0,   1'b0}, {3'b000, 9'd1,   1'b1},
    {3'b001, 9'd2,   1'b0}, {3'b001, 9'd3,   1'b1},
    {3'b010, 9'd5,   1'b0}, {3'b010, 9'd6,   1'b1},
    {3'b011, 9'd7,   1'b0}, {3'b011, 9'd8,   1'b1},
    {3'b101, 9'd127, 1'b0}, {3'b101, 9'd128, 1'b1},
    {3'b110, 9'd191, 1'b0}, {3'b110, 9'd192, 1'b1},
    {3'b111, 9'd255, 1'b0}, {3'b111, 9'd256, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic sz, input logic hi, input logic lo);
    @(negedge clk);
    size_large = sz; thr_hi = hi; thr_lo = lo; wdog_en = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; bit_tick = 1'b0; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 flags", {rx_ready, full, overrun, irq}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {rx_ready, full, overrun, irq, rd_data}, 12'h000);

    // R3/R4: threshold vectors
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][12], VEC[i][11], VEC[i][10]);
      for (int k = 0; k < int'(VEC[i][9:1]); k++) push(k[7:0]);
      chk(VEC[i][12] ? "R4 level" : "R3 level", irq, VEC[i][0]);
      chk(VEC[i][12] ? "R4 count" : "R3 count", count, VEC[i][9:1]);
    end

    // R2: ordering
    do_reset(1'b0, 1'b1, 1'b1);
    push(8'hA1); push(8'hB2); push(8'hC3);
    chk("R2 ready", rx_ready, 1);
    pop(); chk("R2 first", rd_data, 8'hA1);
    pop(); chk("R2 second", rd_data, 8'hB2);
    pop(); chk("R2 third", rd_data, 8'hC3);
    chk("R2 empty", {rx_ready, count}, 0);

    // R12: simultaneous push/pop
    push(8'h11); push(8'h22);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h33; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 count", count, 2);
    chk("R12 data", rd_data, 8'h11);
    pop(); chk("R12 order", rd_data, 8'h22);
    pop(); chk("R12 pushed", rd_data, 8'h33);

    // R5: overflow drop and sticky overrun
    do_reset(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 9; k++) push(8'h40 + k[7:0]);
    chk("R5 count", count, 8);
    chk("R5 full/overrun", {full, overrun}, 2'b11);
    for (int k = 0; k < 8; k++) pop();
    chk("R5 last kept", rd_data, 8'h47);
    chk("R5 sticky", overrun, 1);

    // R6: pop while empty
    pop();
    chk("R6 data", rd_data, 8'h47);
    chk("R6 count", count, 0);

    // R12: full with simultaneous push/pop
    do_reset(1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) push(8'h60 + k[7:0]);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hEE; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 full count", count, 7);
    chk("R12 full data", rd_data, 8'h60);
    chk("R12 full overrun", overrun, 1);

    // R7/R8/R9: stale-data timer
    do_reset(1'b0, 1'b1, 1'b1);
    wdog_en = 1'b1;
    push(8'h55);
    chk("R7 idle", irq, 0);
    ticks(63);
    chk("R7 63 ticks", irq, 0);
    ticks(1);
    @(negedge clk);
    chk("R7 64 ticks", irq, 1);
    push(8'h66);
    chk("R9 latched over push", irq, 1);
    pop();
    chk("R9 cleared by pop", irq, 0);
    ticks(40);
    push(8'h77);
    ticks(40);
    @(negedge clk); @(negedge clk);
    chk("R8 restart on push", irq, 0);
    ticks(30);
    @(negedge clk);
    chk("R8 fires after restart", irq, 1);
    @(negedge clk); wdog_en = 1'b0; #1;
    chk("R10 enable drop", irq, 0);
    wdog_en = 1'b1;
    pop(); pop();
    chk("R8 drained", count, 0);
    ticks(70);
    @(negedge clk);
    chk("R8 empty no fire", irq, 0);

    // R10: code change acts immediately
    do_reset(1'b0, 1'b1, 1'b1);
    push(8'h01); push(8'h02); push(8'h03);
    chk("R10 before", irq, 0);
    @(negedge clk); thr_hi = 1'b0; #1;
    chk("R10 code change", irq, 1);

    // R11: size change flushes and ignores push
    @(negedge clk); size_large = 1'b1; wr_en = 1'b1; wr_data = 8'h99;
    @(negedge clk); wr_en = 1'b0;
    chk("R11 flushed", count, 0);
    push(8'h5A);
    chk("R11 after", count, 1);
    pop();
    chk("R11 data", rd_data, 8'h5A);

    // R1/R5: reset clears overrun
    do_reset(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 9; k++) push(k[7:0]);
    do_reset(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 overrun cleared", {overrun, count}, 0);

    finish_run();
  end
endmodule